// File: doc/BRIEF.md
# Serial ADC Device Interface Logic

This block is the digital side of a 12-bit successive-approximation converter that a host drives with nothing but an active-low chip select and a serial clock. Lowering the chip select captures the parallel sample word, powers the block up, starts the bit-trial sequence and enables the serial data output. Every falling serial clock edge advances the frame by one bit. The frame is sixteen bits long: four zero bits, then the twelve result bits with the most significant bit first.

The analog converter is modelled by a parallel sample input and a bit-trial sequencer. The sequencer decides one result bit per falling serial clock edge, starting at the top bit, so a bit is always decided before it is shifted out. After the sixteenth falling edge the output enable drops and the block returns to its powered-down state by itself. It stays there until the chip select rises and falls again. Raising the chip select in the middle of a frame abandons the conversion at once.

The chip select and serial clock are sampled on the system clock, and events are taken from the change between two samples. Each output therefore responds one system clock after the input edge that causes it.

Top module: `serial_adc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `sdata_oe`, `sdata`, `pwr_active` and `conv_busy` are all 0.
- R2: A falling `cs_n` sets `pwr_active` (1 = active, 0 = powered down) and `sdata_oe`, and captures `sample_in` one system clock later.
- R3: Frame bit 0 appears with the chip-select fall. Frame bit k (1 to 15) appears after the k-th falling `sclk` edge and holds across the following rising edge. Bits 0 to 3 are 0.
- R4: Frame bits 4 to 15 carry the captured sample from bit 11 down to bit 0, in straight binary, so the result equals the captured sample.
- R5: One system clock after the 16th falling `sclk` edge, `sdata_oe` and `pwr_active` are 0.
- R6: A rising `cs_n` before the 16th falling edge clears `sdata_oe`, `pwr_active` and `conv_busy` one system clock later.
- R7: `sclk` edges while the block is powered down, including after a completed frame with `cs_n` still low, leave `sdata_oe` and `pwr_active` at 0.
- R8: Changes on `sample_in` after the chip-select fall have no effect on the bits shifted out.
- R9: The sequencer decides one result bit per falling `sclk` edge, from the top bit down. After the 12th trial the result equals the captured sample.
- R10: `conv_busy` is 1 from the chip-select fall until the 12th falling `sclk` edge, and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; a fall starts a frame |
| sclk | input | 1 | Serial clock; falling edges advance the frame |
| sample_in | input | 12 | Parallel sample word standing in for the analog input |
| sdata | output | 1 | Serial data bit; 0 whenever the output is disabled |
| sdata_oe | output | 1 | Output enable; 0 means the pin is high impedance |
| pwr_active | output | 1 | Power state: 1 active, 0 powered down |
| conv_busy | output | 1 | High while result bits are still being decided |

## Verification
Several rules are checked by assertions on every cycle:
- the leading zeros;
- the data output holding still between frame events;
- release and power-down one cycle after the last edge or an abort;
- stability of the captured sample;
- the sequencer result equalling that sample once the twelfth trial is done.

Only the bench scenarios can show that the whole bit order is correct, that is, that every one of the sixteen positions carries the right value for random and extreme samples. The same holds for `conv_busy` falling on exactly the twelfth edge, and for the block recovering cleanly from aborts at the start, middle and tail of a frame.

// File: rtl/serial_adc_pkg.sv
package serial_adc_pkg;

  typedef enum logic {
    PWR_DOWN   = 1'b0,
    PWR_ACTIVE = 1'b1
  } pwr_state_e;

  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sclk_fall;
  } edge_ev_t;

endpackage

// File: rtl/serial_adc_edges.sv
module serial_adc_edges
  import serial_adc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     sclk,
  output edge_ev_t ev
);

  logic cs_q;
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  always_comb begin
    ev.cs_fall   = cs_q & ~cs_n;
    ev.cs_rise   = ~cs_q & cs_n;
    ev.sclk_fall = sclk_q & ~sclk;
  end

endmodule

// File: rtl/serial_adc_sar.sv
module serial_adc_sar #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic              abort,
  input  logic [DATA_W-1:0] sample_in,
  output logic [DATA_W-1:0] result,
  output logic              busy,
  output logic              sar_last
);

  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] trial_mask;

  // One bit trial: keep the candidate bit if the candidate does not exceed the target.
  function automatic logic [DATA_W-1:0] sar_trial(input logic [DATA_W-1:0] acc,
                                                  input logic [DATA_W-1:0] mask,
                                                  input logic [DATA_W-1:0] target);
    logic [DATA_W-1:0] cand;
    cand = acc | mask;
    return (cand <= target) ? cand : acc;
  endfunction

  assign busy     = |trial_mask;
  assign sar_last = step && trial_mask[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held       <= '0;
      result     <= '0;
      trial_mask <= '0;
    end else if (start) begin
      held       <= sample_in;
      result     <= '0;
      trial_mask <= {1'b1, {(DATA_W-1){1'b0}}};
    end else if (abort) begin
      trial_mask <= '0;
    end else if (step && busy) begin
      result     <= sar_trial(result, trial_mask, held);
      trial_mask <= trial_mask >> 1;
    end
  end

  AST_SAR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sar_last |=> (result == held)); // R9

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(held)); // R8

endmodule

// File: rtl/serial_adc_shifter.sv
module serial_adc_shifter #(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 4,
  parameter int FRAME_LEN  = DATA_W + LEAD_ZEROS,
  parameter int CNT_W      = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic              finish,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] result,
  output logic              sdata,
  output logic              sdata_oe
);

  // Value of frame position idx: leading zeros, then the result from its top bit down.
  function automatic logic frame_bit(input logic [CNT_W-1:0] idx,
                                     input logic [DATA_W-1:0] res);
    logic [DATA_W-1:0] sh;
    if (idx < CNT_W'(LEAD_ZEROS)) return 1'b0;
    sh = res >> (CNT_W'(FRAME_LEN - 1) - idx);
    return sh[0];
  endfunction

  logic [CNT_W-1:0] next_idx;
  assign next_idx = cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
    end else if (start) begin
      sdata    <= frame_bit('0, result);
      sdata_oe <= 1'b1;
    end else if (finish) begin
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
    end else if (step) begin
      sdata    <= frame_bit(next_idx, result);
    end
  end

  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && cnt < CNT_W'(LEAD_ZEROS)) |-> !sdata); // R3

  AST_SDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step && !finish) |=> ($stable(sdata) && $stable(sdata_oe))); // R3

endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl
  import serial_adc_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              pwr_active,
  output logic              conv_busy
);

  localparam int FRAME_LEN = DATA_W + LEAD_ZEROS;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  edge_ev_t          ev;
  pwr_state_e        pwr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] result;
  logic              active;
  logic              start;
  logic              step;
  logic              abort;
  logic              last;
  logic              finish;
  logic              sar_last;

  serial_adc_edges u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .ev    (ev)
  );

  // Named frame events shared by the sub-blocks and the assertions.
  assign active = (pwr == PWR_ACTIVE);
  assign start  = ev.cs_fall;
  assign abort  = active && ev.cs_rise;
  assign step   = active && ev.sclk_fall && !ev.cs_rise && !ev.cs_fall;
  assign last   = step && (cnt == CNT_W'(FRAME_LEN - 1));
  assign finish = abort || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr <= PWR_DOWN;
      cnt <= '0;
    end else if (start) begin
      pwr <= PWR_ACTIVE;
      cnt <= '0;
    end else if (finish) begin
      pwr <= PWR_DOWN;
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  serial_adc_sar #(
    .DATA_W (DATA_W)
  ) u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step      (step),
    .abort     (abort),
    .sample_in (sample_in),
    .result    (result),
    .busy      (conv_busy),
    .sar_last  (sar_last)
  );

  serial_adc_shifter #(
    .DATA_W     (DATA_W),
    .LEAD_ZEROS (LEAD_ZEROS)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .step     (step),
    .finish   (finish),
    .cnt      (cnt),
    .result   (result),
    .sdata    (sdata),
    .sdata_oe (sdata_oe)
  );

  assign pwr_active = active;

  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pwr_active && sdata_oe)); // R2

  AST_DONE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (!pwr_active && !sdata_oe)); // R5

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && active) |=> (!sdata_oe && !pwr_active && !conv_busy)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !ev.cs_fall) |=> (!pwr_active && !sdata_oe)); // R7

  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> active); // R10

  AST_SAR_BEFORE_END: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> !conv_busy); // R10

endmodule

// File: tb/serial_adc_ctrl_test.sv
module serial_adc_ctrl_test;

  localparam int W  = 12;
  localparam int LZ = 4;
  localparam int FL = W + LZ;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic         sdata;
  logic         sdata_oe;
  logic         pwr_active;
  logic         conv_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_adc_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .sample_in  (sample_in),
    .sdata      (sdata),
    .sdata_oe   (sdata_oe),
    .pwr_active (pwr_active),
    .conv_busy  (conv_busy)
  );

  // Expected frame bit: zeros first, then the sample from its top bit down.
  function automatic logic exp_bit(input logic [W-1:0] s, input int k);
    if (k < LZ) return 1'b0;
    return s[FL - 1 - k];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_clocks(input int pulses);
    for (int p = 0; p < pulses; p++) begin
      sclk = 1'b1; tick(2);
      sclk = 1'b0; tick(1);
      chk("R7 oe stays low", sdata_oe, 1'b0);
      chk("R7 stays powered down", pwr_active, 1'b0);
    end
  endtask

  // abort_at: number of falling sclk edges before cs_n rises early; -1 means full frame.
  task automatic frame(input logic [W-1:0] s, input int abort_at);
    sample_in = s;
    cs_n = 1'b0;
    tick(1);
    chk("R2 oe after cs fall", sdata_oe, 1'b1);
    chk("R2 active after cs fall", pwr_active, 1'b1);
    chk("R10 busy after cs fall", conv_busy, 1'b1);
    chk("R3 frame bit 0", sdata, 1'b0);
    sample_in = ~s;  // R8: later changes must not matter
    for (int k = 1; k <= FL; k++) begin
      if (k - 1 == abort_at) begin
        cs_n = 1'b1;
        tick(1);
        chk("R6 oe after abort", sdata_oe, 1'b0);
        chk("R6 power after abort", pwr_active, 1'b0);
        chk("R6 busy after abort", conv_busy, 1'b0);
        tick(2);
        return;
      end
      sclk = 1'b1; tick(2);
      chk($sformatf("R3 bit %0d held over rising edge", k - 1), sdata, exp_bit(s, k - 1));
      sclk = 1'b0; tick(1);
      if (k < FL) begin
        chk($sformatf("R4 R8 frame bit %0d", k), sdata, exp_bit(s, k));
        chk("R3 oe during frame", sdata_oe, 1'b1);
        chk($sformatf("R10 busy after edge %0d", k), conv_busy, (k < W) ? 1'b1 : 1'b0);
      end else begin
        chk("R5 oe after last edge", sdata_oe, 1'b0);
        chk("R5 power after last edge", pwr_active, 1'b0);
        chk("R9 busy after last edge", conv_busy, 1'b0);
      end
    end
    idle_clocks(2);
    cs_n = 1'b1;
    tick(2);
    chk("R7 quiet after cs rise", sdata_oe, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1457));
    tick(2);
    chk("R1 oe in reset", sdata_oe, 1'b0);
    chk("R1 power in reset", pwr_active, 1'b0);
    chk("R1 busy in reset", conv_busy, 1'b0);
    chk("R1 sdata in reset", sdata, 1'b0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 oe after reset", sdata_oe, 1'b0);
    chk("R1 power after reset", pwr_active, 1'b0);

    idle_clocks(3);  // R7 with cs_n high

    frame(12'h000, -1);  // R4 all zeros
    frame(12'hFFF, -1);  // R4 R9 full scale
    frame(12'h800, -1);  // R9 top bit only
    frame(12'h7FF, -1);  // R9 all below top bit
    frame(12'h001, -1);  // R4 least significant bit

    frame(12'hA5A, 0);   // R6 abort before any edge
    frame(12'h3C3, 5);   // R6 abort mid-conversion
    frame(12'hFFF, 14);  // R6 abort in the tail
    frame(12'h5A5, -1);  // recovery after abort

    for (int n = 0; n < 20; n++) begin
      frame(W'($urandom), -1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule